// File: doc/BRIEF.md
# Programmable-Tap Four-Stage LFSR Generator

This block is a four-stage Fibonacci linear feedback shift register whose feedback taps and starting value are set at run time. A four-bit tap word selects which stages feed the XOR that forms the next bit, so one datapath covers every length-four connection polynomial of the form 1 + c1·D + c2·D² + c3·D³ + c4·D⁴. A seed word gives the starting value.

Stepping is paced by an internal divider that raises a one-cycle pulse once every `DIV_COUNT` clocks. The default is 16,666,650 cycles, which is a step period of about 333 ms on a 20 ns clock. A two-state control machine decides what each pulse does. In state `ST_SEED`, a pulse copies the seed into the register and the register does not advance. In state `ST_RUN`, a pulse shifts the register once. The machine samples `run_en` on every clock. Transition `T_ARM` (from `ST_SEED` to `ST_RUN`) is taken when `run_en` is high, and transition `T_DISARM` (from `ST_RUN` to `ST_SEED`) is taken when `run_en` is low. Either transition is therefore seen by the next pulse after the following clock edge. The controller issues one action per clock. The actions, in falling priority, are `ACT_TAPS` (tap load), `ACT_SEED`, `ACT_SHIFT` and `ACT_HOLD`. A synchronous reset overrides all of them.

Top module: `lfsr_prog_gen`

## Requirements
- R1: While `rst` is high, on each rising clock edge `state_out` becomes 4'b0001, the tap register becomes 4'b1001 (c1 and c4 set, polynomial 1 + D + D⁴), the controller enters `ST_SEED`, and the divider restarts.
- R2: `step_pulse` is high for exactly one clock cycle in every `DIV_COUNT` cycles.
- R3: In `ST_RUN`, the new bit is the XOR, over k = 1..4, of tap bit k−1 (ck) AND `state_out` bit 4−k. `state_out` bit 3 holds s3, the newest stage, and bit 0 holds s0, the oldest stage. So c1 gates bit 3 and c4 gates bit 0.
- R4: On a shift, the new bit enters `state_out` bit 3, bits 3..1 move down into bits 2..0, and the old bit 0 is dropped.
- R5: In `ST_SEED`, each pulse loads `seed_in` into `state_out`, and the register does not advance over later pulses.
- R6: An edge on which `tap_load` is high captures `tap_in` into the tap register and leaves `state_out` unchanged, even when `step_pulse` is high on that edge. The new taps are used from the next pulse onward.
- R7: On edges where `step_pulse` is low, `state_out` holds its value whatever `seed_in` does.
- R8: An all-zero state in `ST_RUN` stays all zero on every pulse.
- R9: With taps 4'b1001 and a nonzero seed, the state sequence repeats with a period of exactly 15 steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| seed_in | input | 4 | Starting value loaded in seed mode |
| tap_in | input | 4 | Tap word; bit k−1 is ck |
| tap_load | input | 1 | Capture `tap_in` on this edge |
| run_en | input | 1 | High selects shifting; low selects seed loading |
| state_out | output | 4 | Current register value; bit 3 is the newest stage |
| step_pulse | output | 1 | One-cycle step pulse from the divider |

## Verification
The bench builds the block with `DIV_COUNT` = 5 and keeps the register length at 4. With that setting, a pulse arrives every five clocks. This makes it possible to step a full 15-step period and to compare each step with a software model of the recursion. It also makes it possible to change the taps between pulses, to load taps on the same edge as a pulse, and to reach the all-zero lock-up, all within a few hundred cycles. The short period also lets the bench count the exact gap between pulses.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

    // Controller states: seed copying or shifting
    typedef enum logic {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } lfsr_mode_e;

    // One action per clock, chosen by the controller
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_TAPS  = 2'd1,
        ACT_SEED  = 2'd2,
        ACT_SHIFT = 2'd3
    } lfsr_act_e;

endpackage

// File: rtl/lfsr_strobe_div.sv
module lfsr_strobe_div #(
    parameter int unsigned DIV_COUNT = 16666650
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/lfsr_ctrl_fsm.sv
module lfsr_ctrl_fsm
    import lfsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       tap_load,
    input  logic       tick,
    output lfsr_mode_e mode,
    output lfsr_act_e  act
);
    lfsr_mode_e mode_q;
    lfsr_mode_e mode_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= ST_SEED;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Transitions: T_ARM (seed -> run), T_DISARM (run -> seed)
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_SEED: if (run_en)  mode_d = ST_RUN;
            ST_RUN:  if (!run_en) mode_d = ST_SEED;
            default: mode_d = ST_SEED;
        endcase
    end

    // Outputs: tap load first, then the pulse action of the current state
    always_comb begin
        act = ACT_HOLD;
        if (tap_load) begin
            act = ACT_TAPS;
        end else if (tick) begin
            unique case (mode_q)
                ST_SEED: act = ACT_SEED;
                ST_RUN:  act = ACT_SHIFT;
                default: act = ACT_HOLD;
            endcase
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/lfsr_tap_reg.sv
module lfsr_tap_reg
    import lfsr_pkg::*;
#(
    parameter int unsigned LEN = 4,
    parameter logic [LEN-1:0] RESET_TAPS = 4'b1001
) (
    input  logic           clk,
    input  logic           rst,
    input  lfsr_act_e      act,
    input  logic [LEN-1:0] tap_in,
    output logic [LEN-1:0] taps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= RESET_TAPS;
        end else if (act == ACT_TAPS) begin
            taps <= tap_in;
        end
    end

endmodule

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core
    import lfsr_pkg::*;
#(
    parameter int unsigned LEN = 4,
    parameter logic [LEN-1:0] RESET_STATE = 4'b0001
) (
    input  logic           clk,
    input  logic           rst,
    input  lfsr_act_e      act,
    input  logic [LEN-1:0] taps,
    input  logic [LEN-1:0] seed,
    output logic [LEN-1:0] state
);
    logic [LEN-1:0] gated;
    logic           fb;

    // Coefficient c(k+1) sits in taps[k] and gates stage s(j-k-1),
    // which is held at state[LEN-1-k].
    for (genvar k = 0; k < LEN; k++) begin : g_tap
        assign gated[k] = taps[k] & state[LEN-1-k];
    end

    assign fb = ^gated;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RESET_STATE;
        end else begin
            unique case (act)
                ACT_SEED:  state <= seed;
                ACT_SHIFT: state <= {fb, state[LEN-1:1]};
                default:   state <= state;
            endcase
        end
    end

endmodule

// File: rtl/lfsr_prog_gen.sv
module lfsr_prog_gen
    import lfsr_pkg::*;
#(
    parameter int unsigned LEN = 4,
    parameter int unsigned DIV_COUNT = 16666650,
    parameter logic [LEN-1:0] RESET_TAPS = 4'b1001,
    parameter logic [LEN-1:0] RESET_STATE = 4'b0001
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [LEN-1:0] seed_in,
    input  logic [LEN-1:0] tap_in,
    input  logic           tap_load,
    input  logic           run_en,
    output logic [LEN-1:0] state_out,
    output logic           step_pulse
);
    lfsr_mode_e     mode;
    lfsr_act_e      act;
    logic [LEN-1:0] taps_q;
    logic           run_mode;

    lfsr_strobe_div #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk (clk),
        .rst (rst),
        .tick(step_pulse)
    );

    lfsr_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .run_en  (run_en),
        .tap_load(tap_load),
        .tick    (step_pulse),
        .mode    (mode),
        .act     (act)
    );

    lfsr_tap_reg #(.LEN(LEN), .RESET_TAPS(RESET_TAPS)) u_taps (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .tap_in(tap_in),
        .taps  (taps_q)
    );

    lfsr_shift_core #(.LEN(LEN), .RESET_STATE(RESET_STATE)) u_core (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .taps (taps_q),
        .seed (seed_in),
        .state(state_out)
    );

    assign run_mode = (mode == ST_RUN);

endmodule

// File: rtl/lfsr_prog_gen_chk.sv
module lfsr_prog_gen_chk #(
    parameter int unsigned LEN = 4,
    parameter int unsigned DIV_COUNT = 16666650
) (
    input logic           clk,
    input logic           rst,
    input logic [LEN-1:0] seed_in,
    input logic [LEN-1:0] tap_in,
    input logic           tap_load,
    input logic           step_pulse,
    input logic [LEN-1:0] state_out,
    input logic [LEN-1:0] taps,
    input logic           run_mode
);
    logic [31:0] gap_q;
    logic        seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (step_pulse) begin
            gap_q  <= 32'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 32'hFFFF_FFFF) begin
            gap_q <= gap_q + 32'd1;
        end
    end

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (rst)
        (step_pulse && seen_q) |-> (gap_q == DIV_COUNT)); // R2

    AST_SHIFT_DIR: assert property (@(posedge clk) disable iff (rst)
        (run_mode && step_pulse && !tap_load) |=>
        (state_out[LEN-2:0] == $past(state_out[LEN-1:1]))); // R4

    AST_SEED_COPY: assert property (@(posedge clk) disable iff (rst)
        (!run_mode && step_pulse && !tap_load) |=> (state_out == $past(seed_in))); // R5

    AST_TAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        tap_load |=> (taps == $past(tap_in)) && $stable(state_out)); // R6

    AST_TAP_KEEP: assert property (@(posedge clk) disable iff (rst)
        !tap_load |=> $stable(taps)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step_pulse |=> $stable(state_out)); // R7

    AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (rst)
        (run_mode && step_pulse && (state_out == '0)) |=> (state_out == '0)); // R8

endmodule

bind lfsr_prog_gen lfsr_prog_gen_chk #(.LEN(LEN), .DIV_COUNT(DIV_COUNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seed_in   (seed_in),
    .tap_in    (tap_in),
    .tap_load  (tap_load),
    .step_pulse(step_pulse),
    .state_out (state_out),
    .taps      (taps_q),
    .run_mode  (run_mode)
);

// File: tb/sim_lfsr_prog_gen.sv
`timescale 1ns/1ps
module sim_lfsr_prog_gen;
    localparam int DIV = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] seed_in = 4'b0000;
    logic [3:0] tap_in = 4'b0000;
    logic       tap_load = 1'b0;
    logic       run_en = 1'b0;
    logic [3:0] state_out;
    logic       step_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lfsr_prog_gen #(.LEN(4), .DIV_COUNT(DIV)) u0 (
        .clk(clk), .rst(rst), .seed_in(seed_in), .tap_in(tap_in),
        .tap_load(tap_load), .run_en(run_en),
        .state_out(state_out), .step_pulse(step_pulse)
    );

    // Software model of the recursion: taps[k] is c(k+1), gating s(j-k-1) = bit 3-k
    function automatic logic [3:0] model_next(input logic [3:0] s, input logic [3:0] c);
        logic b;
        b = 1'b0;
        for (int k = 0; k < 4; k++) b = b ^ (c[k] & s[3-k]);
        return {b, s[3], s[2], s[1]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Return at the falling edge where the pulse is high
    task automatic wait_pulse();
        do @(negedge clk); while (step_pulse !== 1'b1);
    endtask

    task automatic step_expect(input logic [3:0] exp, input string req);
        wait_pulse();
        @(negedge clk);
        chk(state_out == exp, req, state_out, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(state_out == 4'b0001, "R1 reset state", state_out, 1);
        chk(step_pulse == 1'b0, "R1 pulse low in reset", step_pulse, 0);
        rst = 1'b0;
    endtask

    task automatic t_pulse_gap();
        int n;
        wait_pulse();
        @(negedge clk);
        chk(step_pulse == 1'b0, "R2 pulse one cycle", step_pulse, 0);
        n = 1;
        while (step_pulse !== 1'b1) begin
            @(negedge clk);
            n++;
        end
        chk(n == DIV, "R2 pulse gap", n, DIV);
        @(negedge clk);
    endtask

    task automatic t_seed_mode();
        run_en = 1'b0;
        seed_in = 4'b1010;
        step_expect(4'b1010, "R5 seed loaded");
        seed_in = 4'b0110;
        @(negedge clk);
        chk(state_out == 4'b1010, "R7 seed change ignored between pulses", state_out, 4'b1010);
        @(negedge clk);
        chk(state_out == 4'b1010, "R7 still held", state_out, 4'b1010);
        step_expect(4'b0110, "R5 new seed on pulse");
        step_expect(4'b0110, "R5 no advance in seed mode");
    endtask

    task automatic t_period();
        logic [3:0] m;
        bit early;
        seed_in = 4'b0001;
        run_en = 1'b0;
        step_expect(4'b0001, "R5 seed 0001");
        // Taps are still the reset value 1001 here
        run_en = 1'b1;
        m = 4'b0001;
        early = 1'b0;
        for (int i = 1; i <= 15; i++) begin
            m = model_next(m, 4'b1001);
            step_expect(m, "R3 R4 step vs model");
            if (i < 15 && state_out == 4'b0001) early = 1'b1;
        end
        chk(!early, "R9 no early repeat", early, 0);
        chk(state_out == 4'b0001, "R9 period 15", state_out, 1);
    endtask

    task automatic t_tap_change();
        logic [3:0] m;
        m = state_out;
        tap_in = 4'b1100;
        tap_load = 1'b1;
        @(negedge clk);
        tap_load = 1'b0;
        chk(state_out == m, "R6 tap load keeps state", state_out, m);
        for (int i = 0; i < 4; i++) begin
            m = model_next(m, 4'b1100);
            step_expect(m, "R3 new taps 1100");
        end
    endtask

    task automatic t_tap_on_pulse();
        logic [3:0] m;
        wait_pulse();
        m = state_out;
        tap_in = 4'b0011;
        tap_load = 1'b1;
        @(negedge clk);
        tap_load = 1'b0;
        chk(state_out == m, "R6 load on pulse edge keeps state", state_out, m);
        m = model_next(m, 4'b0011);
        step_expect(m, "R6 taps 0011 used at next pulse");
    endtask

    task automatic t_zero_lock();
        run_en = 1'b0;
        seed_in = 4'b0000;
        tap_in = 4'b1001;
        tap_load = 1'b1;
        @(negedge clk);
        tap_load = 1'b0;
        step_expect(4'b0000, "R8 zero seeded");
        run_en = 1'b1;
        for (int i = 0; i < 3; i++) step_expect(4'b0000, "R8 zero stays zero");
    endtask

    initial begin
        t_reset();
        t_pulse_gap();
        t_seed_mode();
        t_period();
        t_tap_change();
        t_tap_on_pulse();
        t_zero_lock();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule